// File: doc/BRIEF.md
# ADC Master Clock and Sample-Trigger Generator

This block takes one fast reference clock and produces the two timing signals an external high-speed ADC needs: a master clock obtained by integer division of the reference, and a narrow sample-trigger pulse. The trigger repeats once every N master-clock periods, where N follows a channel-mode input: 5 periods for a single channel, 8 for two channels and 13 for three. Inside each master-clock period the trigger starts at a fixed reference-cycle offset after the master-clock rising edge and stays high for a fixed number of reference cycles. Both numbers are parameters, and they are checked against the converter's timing limits when the design is elaborated.

A rising edge on an external sync input passes through a two-flop synchronizer. It then restarts the divider phase and the trigger sequence, so the trigger train can be locked to an outside reference. A mode change takes effect only when the trigger period in progress ends, so an interval is never cut short or stretched. A one-cycle sample strobe goes out together with every trigger rising edge, so that capture logic can count samples. Once configured, the block needs no software.

Top module: `adc_trigger_gen`

## Requirements
- R1: While rstN is low, mclk, vsmp and sampleStb are all low. After reset the sequence begins at the first master-clock period of a trigger period.
- R2: mclk has a period of DIV reference cycles. It is high for DIV/2 cycles (rounded down) starting at divider phase 0 and low for the rest, so DIV=4 gives a 50% duty cycle and DIV=5 gives 2 high to 3 low.
- R3: The trigger period is LEN_ONE, LEN_TWO or LEN_THREE master-clock periods (5, 8, 13) for chanMode 0, 1 and 2. chanMode 3 behaves like 2.
- R4: Each vsmp pulse is high for exactly PULSE_W reference cycles. Elaboration rejects a PULSE_W whose duration, at REF_PERIOD_PS, falls outside 5 ns to 12.5 ns.
- R5: vsmp rises RISE_OFS reference cycles after the mclk rising edge that starts the first master-clock period of each trigger period. Elaboration rejects an offset below 3 ns, and a fall that comes less than 7 ns after the mclk falling edge.
- R6: A new chanMode value is adopted only when the current trigger period ends, or on a restart or while disabled. The interval in progress keeps its old length.
- R7: A rising edge on syncIn, after two synchronizer flops, restarts the divider phase and the period counter and adopts chanMode. The next strobe appears 4+RISE_OFS reference cycles after syncIn was driven high. A restart in the same cycle as a trigger wins, and that trigger is dropped.
- R8: sampleStb is high for one reference cycle, in the same cycle in which vsmp rises.
- R9: While enable is low, all three outputs are low one cycle later. When enable returns, the sequence starts afresh from phase 0 of the first period, in the current chanMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds the outputs low and rewinds the sequence |
| chanMode | input | 2 | Channel-count select: 0 one, 1 two, 2 or 3 three |
| syncIn | input | 1 | External resync, asynchronous, rising-edge active |
| mclk | output | 1 | ADC master clock |
| vsmp | output | 1 | ADC sample-trigger pulse |
| sampleStb | output | 1 | One-cycle flag at each trigger rising edge |

## Verification
The interesting collision is a synchronized sync edge that lands in the same reference cycle in which the trigger for slot 0 would have fired. A directed case times the syncIn pulse to exactly that cycle. It expects no strobe at the natural position, and exactly one strobe 4+RISE_OFS cycles after syncIn rose. A second case changes chanMode in the middle of a period and checks that the period in progress keeps its old length. Random sync pulses, mode changes and enable drops are then compared cycle by cycle with a bench model built from the requirements.

// File: rtl/adcgen_pkg.sv
package adcgen_pkg;
  // strobes from sequence control to the clock/pulse datapath
  typedef struct packed {
    logic idle;     // block disabled: rewind and silence outputs
    logic restart;  // synchronized sync edge: rewind phase
    logic fire;     // start a trigger pulse this cycle
  } ctlStrobe_t;

  function automatic int unsigned lenMax(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adcgen_ctrl.sv
module adcgen_ctrl
  import adcgen_pkg::*;
#(
  parameter int unsigned RISE_OFS  = 2,
  parameter int unsigned LEN_ONE   = 5,
  parameter int unsigned LEN_TWO   = 8,
  parameter int unsigned LEN_THREE = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] chanMode,
  input  logic       syncIn,
  input  logic       phaseWrap,
  input  logic       phaseAtRise,
  output ctlStrobe_t ctl
);
  localparam int unsigned MAX_LEN = lenMax(LEN_ONE, LEN_TWO, LEN_THREE);
  localparam int unsigned SLOT_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [2:0]        syncPipe;
  logic              syncRise;
  logic [1:0]        activeMode;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] curLast;
  logic              periodEnd;
  logic              loadMode;

  // two synchronizer flops plus one edge-detect flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], syncIn};
  end
  assign syncRise = syncPipe[1] & ~syncPipe[2];

  always_comb begin
    unique case (activeMode)
      2'd0:    curLast = SLOT_W'(LEN_ONE - 1);
      2'd1:    curLast = SLOT_W'(LEN_TWO - 1);
      default: curLast = SLOT_W'(LEN_THREE - 1);
    endcase
  end

  assign periodEnd = phaseWrap && (slot == curLast);
  assign ctl.idle    = !enable;
  assign ctl.restart = enable && syncRise;
  assign ctl.fire    = enable && !syncRise && (slot == '0) && phaseAtRise;
  assign loadMode    = ctl.idle || ctl.restart || periodEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot       <= '0;
      activeMode <= 2'd0;
    end else if (ctl.idle || ctl.restart) begin
      slot       <= '0;
      activeMode <= chanMode;
    end else if (periodEnd) begin
      slot       <= '0;
      activeMode <= chanMode;
    end else if (phaseWrap) begin
      slot <= slot + 1'b1;
    end
  end

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    slot <= curLast);
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode != $past(activeMode)) |-> $past(loadMode));
  assert_restart_rewinds_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.restart) |-> (slot == '0));
endmodule

// File: rtl/adcgen_datapath.sv
module adcgen_datapath
  import adcgen_pkg::*;
#(
  parameter int unsigned DIV      = 4,
  parameter int unsigned HIGH_CYC = 2,
  parameter int unsigned RISE_OFS = 2,
  parameter int unsigned PULSE_W  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       phaseWrap,
  output logic       phaseAtRise,
  output logic       mclk,
  output logic       vsmp,
  output logic       sampleStb
);
  localparam int unsigned PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned CNT_W = $clog2(PULSE_W + 1);
  localparam int unsigned RUN_W = $clog2(PULSE_W + DIV + 2) + 1;

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] pulseLeft;

  assign phaseWrap   = (phase == PH_W'(DIV - 1));
  assign phaseAtRise = (phase == PH_W'(RISE_OFS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        phase <= '0;
    else if (ctl.idle || ctl.restart) phase <= '0;
    else if (phaseWrap)               phase <= '0;
    else                              phase <= phase + 1'b1;
  end

  // all outputs come straight from flops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclk      <= 1'b0;
      vsmp      <= 1'b0;
      sampleStb <= 1'b0;
      pulseLeft <= '0;
    end else begin
      mclk      <= !ctl.idle && (phase < PH_W'(HIGH_CYC));
      sampleStb <= ctl.fire;
      if (ctl.idle) begin
        vsmp      <= 1'b0;
        pulseLeft <= '0;
      end else if (ctl.fire) begin
        vsmp      <= 1'b1;
        pulseLeft <= CNT_W'(PULSE_W - 1);
      end else if (pulseLeft != '0) begin
        vsmp      <= 1'b1;
        pulseLeft <= pulseLeft - 1'b1;
      end else begin
        vsmp      <= 1'b0;
      end
    end
  end

  // run-length observer for the pulse width check
  logic [RUN_W-1:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     highRun <= '0;
    else if (vsmp) highRun <= highRun + 1'b1;
    else           highRun <= '0;
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!vsmp && highRun != '0 && !$past(ctl.idle)) |-> (highRun == RUN_W'(PULSE_W)));
  assert_pulse_not_long_R4: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= RUN_W'(PULSE_W));
  assert_strobe_on_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (vsmp && !$past(vsmp)));
  assert_mclk_rise_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mclk) |-> ($past(phase) == '0));
endmodule

// File: rtl/adc_trigger_gen.sv
module adc_trigger_gen
  import adcgen_pkg::*;
#(
  parameter int unsigned DIV           = 4,
  parameter int unsigned RISE_OFS      = 2,
  parameter int unsigned PULSE_W       = 2,
  parameter int unsigned REF_PERIOD_PS = 6250,
  parameter int unsigned LEN_ONE       = 5,
  parameter int unsigned LEN_TWO       = 8,
  parameter int unsigned LEN_THREE     = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] chanMode,
  input  logic       syncIn,
  output logic       mclk,
  output logic       vsmp,
  output logic       sampleStb
);
  localparam int unsigned HIGH_CYC   = DIV / 2;
  localparam int unsigned RISE_PS    = RISE_OFS * REF_PERIOD_PS;
  localparam int unsigned WIDTH_PS   = PULSE_W * REF_PERIOD_PS;
  localparam int unsigned FALL_AT    = RISE_OFS + PULSE_W;
  localparam bit          TIMING_OK  = (DIV >= 2) && (RISE_OFS < DIV) && (PULSE_W >= 1)
                                    && (RISE_PS >= 3000)
                                    && (WIDTH_PS >= 5000) && (WIDTH_PS <= 12500)
                                    && (FALL_AT > HIGH_CYC)
                                    && ((FALL_AT - HIGH_CYC) * REF_PERIOD_PS >= 7000);

  generate
    if (!TIMING_OK) begin : g_timing_reject
      $error("adc_trigger_gen: RISE_OFS/PULSE_W violate converter timing limits");
    end
  endgenerate

  ctlStrobe_t ctl;
  logic       phaseWrap;
  logic       phaseAtRise;

  adcgen_ctrl #(
    .RISE_OFS (RISE_OFS),
    .LEN_ONE  (LEN_ONE),
    .LEN_TWO  (LEN_TWO),
    .LEN_THREE(LEN_THREE)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .chanMode   (chanMode),
    .syncIn     (syncIn),
    .phaseWrap  (phaseWrap),
    .phaseAtRise(phaseAtRise),
    .ctl        (ctl)
  );

  adcgen_datapath #(
    .DIV     (DIV),
    .HIGH_CYC(HIGH_CYC),
    .RISE_OFS(RISE_OFS),
    .PULSE_W (PULSE_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .phaseWrap  (phaseWrap),
    .phaseAtRise(phaseAtRise),
    .mclk       (mclk),
    .vsmp       (vsmp),
    .sampleStb  (sampleStb)
  );
endmodule

// File: tb/test_adc_trigger_gen.sv
`timescale 1ns/1ps
module test_adc_trigger_gen;
  localparam int DIV = 4;
  localparam int RISE = 2;
  localparam int PW = 2;
  localparam int HIGHC = DIV / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] chanMode = 2'd0;
  logic syncIn = 1'b0;
  logic mclk, vsmp, sampleStb;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  adc_trigger_gen i_adc_trigger_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .chanMode(chanMode),
    .syncIn(syncIn), .mclk(mclk), .vsmp(vsmp), .sampleStb(sampleStb)
  );

  function automatic int lenOf(input logic [1:0] m);
    return (m == 2'd0) ? 5 : (m == 2'd1) ? 8 : 13;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // reference model built from the requirements
  int mPhase, mSlot, mCnt;
  logic [1:0] mMode;
  logic ms1, ms2, ms3;
  logic eMclk, eVsmp, eStb;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mSlot = 0; mCnt = 0; mMode = 2'd0;
      ms1 = 0; ms2 = 0; ms3 = 0;
      eMclk = 0; eVsmp = 0; eStb = 0;
    end else begin
      logic rise, fireNow;
      rise    = ms2 & ~ms3;
      fireNow = enable && !rise && mSlot == 0 && mPhase == RISE;
      eMclk   = enable && mPhase < HIGHC;
      eStb    = fireNow;
      if (!enable) begin eVsmp = 0; mCnt = 0; end
      else if (fireNow) begin eVsmp = 1; mCnt = PW - 1; end
      else if (mCnt != 0) begin eVsmp = 1; mCnt--; end
      else eVsmp = 0;
      if (!enable || rise) begin
        mPhase = 0; mSlot = 0; mMode = chanMode;
      end else if (mPhase == DIV - 1) begin
        mPhase = 0;
        if (mSlot == lenOf(mMode) - 1) begin mSlot = 0; mMode = chanMode; end
        else mSlot++;
      end else mPhase++;
      ms3 = ms2; ms2 = ms1; ms1 = syncIn;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R2 mclk", mclk, eMclk);
      check("R4/R6/R7 vsmp", vsmp, eVsmp);
      check("R8 sampleStb", sampleStb, eStb);
    end
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  task automatic waitStrobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sampleStb && n < 200);
  endtask

  task automatic pulseSync();
    @(negedge clk); syncIn = 1'b1;
    @(negedge clk); syncIn = 1'b0;
  endtask

  initial begin
    int n, w;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low
    check("R1 mclk in reset", mclk, 0);
    check("R1 vsmp in reset", vsmp, 0);
    check("R1 strobe in reset", sampleStb, 0);
    rstN = 1'b1;
    @(negedge clk); enable = 1'b1;

    // R3: period per mode, R4 width, R5 position against mclk
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); chanMode = m[1:0];
      waitStrobe(n); waitStrobe(n); waitStrobe(n);
      check($sformatf("R3 period mode %0d", m), n, lenOf(m[1:0]) * DIV);
      // R5: at vsmp rise mclk has been high HIGHC cycles then low RISE-HIGHC
      check("R5 mclk at vsmp rise", mclk, (RISE < HIGHC) ? 1 : 0);
      w = 1;
      while (vsmp) begin @(negedge clk); if (vsmp) w++; end
      check("R4 vsmp width", w, PW);
    end

    // R6: mode change mid-period keeps old length for the current interval
    @(negedge clk); chanMode = 2'd0;
    waitStrobe(n); waitStrobe(n);
    repeat (3) @(negedge clk);
    chanMode = 2'd2;
    waitStrobe(n);
    check("R6 interval after change", n + 3, 5 * DIV);
    waitStrobe(n);
    check("R6 next interval uses new mode", n, 13 * DIV);

    // R7: plain resync after a strobe
    waitStrobe(n);
    @(negedge clk); syncIn = 1'b1; n = 0;
    @(negedge clk); syncIn = 1'b0; n = 1;
    while (!sampleStb && n < 100) begin @(negedge clk); n++; end
    check("R7 resync latency", n, 4 + RISE);

    // R7: restart coincides with the natural slot-0 fire
    @(negedge clk); chanMode = 2'd0;
    waitStrobe(n); waitStrobe(n);
    repeat (5 * DIV - 3) @(negedge clk);
    syncIn = 1'b1; n = 0;
    @(negedge clk); syncIn = 1'b0; n = 1;
    while (!sampleStb && n < 100) begin @(negedge clk); n++; end
    check("R7 collision: first strobe from restart", n, 4 + RISE);

    // R9: disable silences outputs
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R9 mclk low when disabled", mclk, 0);
    check("R9 vsmp low when disabled", vsmp, 0);
    repeat (7) @(negedge clk);
    check("R9 strobe low when disabled", sampleStb, 0);
    enable = 1'b1; n = 0;
    while (!sampleStb && n < 100) begin @(negedge clk); n++; end
    check("R9 first strobe after enable", n, RISE + 1);

    // random mix, judged by the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 60) == 0) chanMode = 2'($urandom_range(0, 3));
      syncIn = ($urandom_range(0, 90) == 0);
      if ($urandom_range(0, 400) == 0) enable = ~enable;
      if (!enable && $urandom_range(0, 8) == 0) enable = 1'b1;
    end
    syncIn = 1'b0;
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule